// File: doc/BRIEF.md
# Memory Wait-State Timing Controller

This block turns a 16-bit wait-control word into access cycle counts for a memory map split into 16 regions. Each request names a region index (the top address bits), a width of 16 or 32 bits, a sequential flag, an instruction-fetch flag, a read/write flag and a burst length in 32-bit words. The block returns three values. The first is the wait count for the single access. The second is the total cycle cost of that access. The third is the total cost of a burst of 32-bit words that starts in that region.

The block is the timing authority that sits beside a bus master. When a request is accepted, the block raises `stall` for exactly the wait count, then gives one `ack` pulse. No new request is taken until that pulse has been given. The control word sets the cost of the three cartridge ROM windows and of the save RAM. One bit of it turns on a prefetch buffer, which hides the wait of instruction fetches from ROM. Until the first write to the control word, a fixed boot timing table applies.

Top module: `mem_wait_timer`

## Requirements
- R1: Before the first control write, the 16-bit non-sequential / 16-bit sequential / 32-bit non-sequential / 32-bit sequential waits are:
  - regions 8–9: 4/2/7/5
  - regions 10–11: 4/4/9/9
  - regions 12–13: 4/8/13/17
  - region 14: 4/4/9/9
  - region 15: 0/0/0/0
  
  Prefetch is off in this state.
- R2: After a write, the 16-bit non-sequential wait of ROM window 0 (regions 8–9) is taken from bits [3:2]. Window 1 (regions 10–11) uses bits [6:5] and window 2 (regions 12–13) uses bits [9:8]. Codes 0, 1, 2 and 3 give 4, 3, 2 and 8.
- R3: After a write, the 16-bit sequential wait comes from one bit per window: bit 4 for window 0, bit 7 for window 1 and bit 10 for window 2. With the bit clear the wait is 2, 4 or 8 for windows 0, 1 and 2. With the bit set it is 1.
- R4: After a write, both 32-bit waits of a ROM window equal twice its 16-bit sequential wait plus one.
- R5: After a write, regions 14 and 15 (save RAM) use the value selected by bits [1:0] from the same 4/3/2/8 set. That value is the 16-bit wait for both sequential and non-sequential accesses. Both 32-bit waits are twice that value plus one.
- R6: The two regions of a ROM window always have identical timing.
- R7: When bit 14 is set, an instruction fetch from regions 8–13 has a wait of 0. With bit 14 clear, instruction fetches use the data waits. The save RAM and the burst total are never affected by bit 14.
- R8: Regions 0, 1 and 3–7, and every region index of 16 or above, have zero wait. Region 2 has the fixed waits 2/2/5/5.
- R9: The access cost is 2 plus the wait for a read and 1 plus the wait for a write.
- R10: The burst total for N words is (1 + 32-bit non-sequential wait) + (N − 1) × (1 + 32-bit sequential wait), using data waits. N = 0 gives 0.
- R11: After an accepted request, `stall` is high for exactly the wait count of cycles. One single-cycle `ack` follows. `req_ready` is low from acceptance until after `ack`, and requests offered while it is low are ignored.
- R12: A control write sampled on a clock edge affects only requests sampled on later edges. A request sampled on the same edge uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| req_valid | input | 1 | Request offered |
| req_region | input | REGION_W | Region index (top address bits) |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | 1 = sequential access |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | BEAT_W | Burst length in 32-bit words |
| req_ready | output | 1 | High when a request can be accepted |
| stall | output | 1 | Wait-state stall |
| ack | output | 1 | One-cycle completion pulse |
| wait_cycles | output | WAIT_W | Wait count of the last accepted request |
| access_cycles | output | WAIT_W+1 | Access cost of the last accepted request |
| burst_cycles | output | WAIT_W+BEAT_W+1 | Burst total of the last accepted request |

## Verification
Some behaviours are checked by assertions on every cycle:
- the stall run length matches the latched wait count, and the acknowledge is a single pulse;
- `req_ready` stays low while an access is in flight;
- a prefetch-hidden ROM fetch, or a region index of 16 or above, goes straight to acknowledge;
- the control word holds between writes.

Other behaviours only the bench scenarios can show:
- the numeric decoding of every register field;
- the boot table and the save RAM mirror;
- the burst arithmetic;
- the same-edge ordering of a write against a request;
- the dropping of requests offered while busy.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

   localparam int unsigned TW   = 5;   // holds the largest wait (17)
   localparam int unsigned NWIN = 3;   // ROM windows in the control word

   typedef struct packed {
      logic [TW-1:0] ns16;
      logic [TW-1:0] s16;
      logic [TW-1:0] ns32;
      logic [TW-1:0] s32;
   } tim_t;

   function automatic tim_t mk_tim(input int unsigned a, input int unsigned b,
                                   input int unsigned c, input int unsigned d);
      tim_t t;
      t.ns16 = TW'(a);
      t.s16  = TW'(b);
      t.ns32 = TW'(c);
      t.s32  = TW'(d);
      return t;
   endfunction

   // two-bit code to wait: 4, 3, 2, 8
   function automatic logic [TW-1:0] code_wait(input logic [1:0] c);
      case (c)
         2'd0:    return TW'(4);
         2'd1:    return TW'(3);
         2'd2:    return TW'(2);
         default: return TW'(8);
      endcase
   endfunction

   // slow sequential wait per window: 2, 4, 8
   function automatic logic [TW-1:0] slow_seq(input int unsigned w);
      return TW'(2 << w);
   endfunction

   function automatic tim_t boot_win(input int unsigned w);
      case (w)
         0:       return mk_tim(4, 2, 7, 5);
         1:       return mk_tim(4, 4, 9, 9);
         default: return mk_tim(4, 8, 13, 17);
      endcase
   endfunction

endpackage

// File: rtl/mwt_cfg_bank.sv
module mwt_cfg_bank
   import mwt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [15:0]           cfg_wdata,
   output tim_t [NWIN-1:0]       win_tim,
   output tim_t                  sram_tim,
   output logic                  mirror_live,
   output logic                  pf_en
);

   logic [15:0] cfg_q;
   logic        loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         loaded_q <= 1'b0;
      end else if (cfg_we) begin
         cfg_q    <= cfg_wdata;
         loaded_q <= 1'b1;
      end
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam int unsigned NS_LO  = 2 + 3 * w;
      localparam int unsigned SEQ_BT = 4 + 3 * w;
      logic [TW-1:0] ns16, s16, d32;
      tim_t          live;
      always_comb begin
         ns16      = code_wait(cfg_q[NS_LO +: 2]);
         s16       = cfg_q[SEQ_BT] ? TW'(1) : slow_seq(w);
         d32       = TW'({s16, 1'b1});
         live.ns16 = ns16;
         live.s16  = s16;
         live.ns32 = d32;
         live.s32  = d32;
      end
      assign win_tim[w] = loaded_q ? live : boot_win(w);
   end

   logic [TW-1:0] sv, sv32;
   always_comb begin
      sv   = code_wait(cfg_q[1:0]);
      sv32 = TW'({sv, 1'b1});
      if (loaded_q) begin
         sram_tim.ns16 = sv;
         sram_tim.s16  = sv;
         sram_tim.ns32 = sv32;
         sram_tim.s32  = sv32;
      end else begin
         sram_tim = mk_tim(4, 4, 9, 9);
      end
   end

   assign mirror_live = loaded_q;
   assign pf_en       = loaded_q & cfg_q[14];

   // R12: the stored word changes only through a write
   assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/mwt_lookup.sv
module mwt_lookup
   import mwt_pkg::*;
#(
   parameter int unsigned REGION_W = 8
) (
   input  logic [REGION_W-1:0] region,
   input  logic                wide,
   input  logic                seq,
   input  logic                fetch,
   input  tim_t [NWIN-1:0]     win_tim,
   input  tim_t                sram_tim,
   input  logic                mirror_live,
   input  logic                pf_en,
   output logic [TW-1:0]       wait_o,
   output logic [TW-1:0]       ns32_o,
   output logic [TW-1:0]       s32_o
);

   logic far;
   if (REGION_W > 4) begin : g_far
      assign far = |region[REGION_W-1:4];
   end else begin : g_near
      assign far = 1'b0;
   end

   tim_t          t;
   logic          rom;
   logic [TW-1:0] pick;

   always_comb begin
      t   = '0;
      rom = 1'b0;
      if (!far) begin
         case (region[3:0])
            4'd2:        t = mk_tim(2, 2, 5, 5);
            4'd8, 4'd9:  begin t = win_tim[0]; rom = 1'b1; end
            4'd10, 4'd11: begin t = win_tim[1]; rom = 1'b1; end
            4'd12, 4'd13: begin t = win_tim[2]; rom = 1'b1; end
            4'd14:       t = sram_tim;
            4'd15:       t = mirror_live ? sram_tim : '0;
            default:     t = '0;
         endcase
      end
      if (wide) pick = seq ? t.s32 : t.ns32;
      else      pick = seq ? t.s16 : t.ns16;
      wait_o = (fetch && rom && pf_en) ? '0 : pick;
      ns32_o = t.ns32;
      s32_o  = t.s32;
   end

endmodule

// File: rtl/mwt_stall_seq.sv
module mwt_stall_seq #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept_i,
   input  logic [W-1:0] len_i,
   output logic         stall_o,
   output logic         ack_o,
   output logic         ready_o
);

   typedef enum logic [1:0] {S_IDLE, S_STALL, S_ACK} st_t;
   st_t          st_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            S_IDLE:
               if (accept_i) begin
                  cnt_q <= len_i;
                  st_q  <= (len_i == '0) ? S_ACK : S_STALL;
               end
            S_STALL: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == W'(1)) st_q <= S_ACK;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign stall_o = (st_q == S_STALL);
   assign ack_o   = (st_q == S_ACK);
   assign ready_o = (st_q == S_IDLE);

   // checker: measure the stall run against the accepted length
   logic [W-1:0] len_q, run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         run_q <= '0;
      end else if (accept_i) begin
         len_q <= len_i;
         run_q <= '0;
      end else if (stall_o) begin
         run_q <= run_q + 1'b1;
      end
   end

   // R11: stall lasts exactly the wait count
   assert_stall_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (run_q == len_q));
   // R11: acknowledge is a single pulse
   assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
   // R11: no acceptance while busy
   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o || ack_o) |-> !ready_o);

endmodule

// File: rtl/mem_wait_timer.sv
module mem_wait_timer
   import mwt_pkg::*;
#(
   parameter int unsigned REGION_W = 8,
   parameter int unsigned BEAT_W   = 8,
   parameter int unsigned WAIT_W   = 5,
   localparam int unsigned ACC_W   = WAIT_W + 1,
   localparam int unsigned BURST_W = WAIT_W + BEAT_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [15:0]         cfg_wdata,
   input  logic                req_valid,
   input  logic [REGION_W-1:0] req_region,
   input  logic                req_wide,
   input  logic                req_seq,
   input  logic                req_fetch,
   input  logic                req_write,
   input  logic [BEAT_W-1:0]   req_beats,
   output logic                req_ready,
   output logic                stall,
   output logic                ack,
   output logic [WAIT_W-1:0]   wait_cycles,
   output logic [ACC_W-1:0]    access_cycles,
   output logic [BURST_W-1:0]  burst_cycles
);

   if (WAIT_W < TW) begin : g_bad_wait
      $error("WAIT_W too narrow for the largest wait");
   end
   if (REGION_W < 4) begin : g_bad_region
      $error("REGION_W must cover 16 regions");
   end
   if (BEAT_W < 1) begin : g_bad_beat
      $error("BEAT_W must be at least 1");
   end

   tim_t [NWIN-1:0] win_tim;
   tim_t            sram_tim;
   logic            mirror_live, pf_en;

   mwt_cfg_bank u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .win_tim(win_tim), .sram_tim(sram_tim),
      .mirror_live(mirror_live), .pf_en(pf_en)
   );

   logic [TW-1:0] w_raw, ns32, s32;

   mwt_lookup #(.REGION_W(REGION_W)) u_look (
      .region(req_region), .wide(req_wide), .seq(req_seq), .fetch(req_fetch),
      .win_tim(win_tim), .sram_tim(sram_tim), .mirror_live(mirror_live),
      .pf_en(pf_en), .wait_o(w_raw), .ns32_o(ns32), .s32_o(s32)
   );

   logic [WAIT_W-1:0]  w_ext;
   logic [ACC_W-1:0]   acc_d;
   logic [BURST_W-1:0] burst_d, first_b, step_b, rest_n;

   always_comb begin
      w_ext   = WAIT_W'(w_raw);
      acc_d   = ACC_W'(w_ext) + (req_write ? ACC_W'(1) : ACC_W'(2));
      first_b = BURST_W'(ns32) + BURST_W'(1);
      step_b  = BURST_W'(s32) + BURST_W'(1);
      rest_n  = BURST_W'(req_beats) - BURST_W'(1);
      burst_d = (req_beats == '0) ? '0 : first_b + rest_n * step_b;
   end

   logic accept;
   assign accept = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cycles   <= '0;
         access_cycles <= '0;
         burst_cycles  <= '0;
      end else if (accept) begin
         wait_cycles   <= w_ext;
         access_cycles <= acc_d;
         burst_cycles  <= burst_d;
      end
   end

   mwt_stall_seq #(.W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .len_i(w_ext),
      .stall_o(stall), .ack_o(ack), .ready_o(req_ready)
   );

   logic rom_rg, far_rg;
   assign rom_rg = (req_region >= REGION_W'(8)) && (req_region <= REGION_W'(13));
   assign far_rg = (req_region >= REGION_W'(16));

   // R7: prefetch-hidden ROM fetch completes without stalling
   assert_prefetch_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_fetch && pf_en && rom_rg) |=> (ack && !stall));
   // R8: regions past the map complete without stalling
   assert_far_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && far_rg) |=> (ack && !stall));

endmodule

// File: tb/mem_wait_timer_bench.sv
`timescale 1ns/1ps
module mem_wait_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_region = '0;
   logic        req_wide = 1'b0, req_seq = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
   logic [7:0]  req_beats = '0;
   logic        req_ready, stall, ack;
   logic [4:0]  wait_cycles;
   logic [5:0]  access_cycles;
   logic [13:0] burst_cycles;

   always #5 clk = ~clk;

   mem_wait_timer u_mem_wait_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
      .req_seq(req_seq), .req_fetch(req_fetch), .req_write(req_write),
      .req_beats(req_beats), .req_ready(req_ready), .stall(stall), .ack(ack),
      .wait_cycles(wait_cycles), .access_cycles(access_cycles),
      .burst_cycles(burst_cycles)
   );

   int  n_chk = 0, n_bad = 0;
   bit  done = 1'b0;

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   typedef struct packed {
      logic [15:0] cfg;
      logic [7:0]  region;
      logic        wide, seq, fetch, wr;
      logic [7:0]  beats;
      logic [4:0]  ew;
      logic [5:0]  ea;
      logic [13:0] eb;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VT [0:16] = '{
      '{16'h0000, 8'd8,   1'b0,1'b0,1'b0,1'b0, 8'd4, 5'd4,  6'd6,  14'd24, 8'd2},  // R2 R10
      '{16'h0000, 8'd8,   1'b1,1'b1,1'b0,1'b0, 8'd1, 5'd5,  6'd7,  14'd6,  8'd4},  // R4
      '{16'h0014, 8'd9,   1'b0,1'b0,1'b0,1'b0, 8'd3, 5'd3,  6'd5,  14'd12, 8'd2},  // R2 R6
      '{16'h0014, 8'd9,   1'b0,1'b1,1'b0,1'b1, 8'd0, 5'd1,  6'd2,  14'd0,  8'd3},  // R3 R9 R10
      '{16'h0060, 8'd10,  1'b0,1'b0,1'b0,1'b0, 8'd2, 5'd8,  6'd10, 14'd20, 8'd2},  // R2
      '{16'h00C0, 8'd11,  1'b1,1'b1,1'b0,1'b0, 8'd2, 5'd3,  6'd5,  14'd8,  8'd3},  // R3 R6
      '{16'h0200, 8'd12,  1'b1,1'b0,1'b0,1'b1, 8'd1, 5'd17, 6'd18, 14'd18, 8'd4},  // R4 R9
      '{16'h0700, 8'd13,  1'b0,1'b0,1'b0,1'b0, 8'd5, 5'd8,  6'd10, 14'd20, 8'd6},  // R6 R10
      '{16'h0003, 8'd14,  1'b0,1'b1,1'b0,1'b0, 8'd2, 5'd8,  6'd10, 14'd36, 8'd5},  // R5
      '{16'h0002, 8'd15,  1'b1,1'b0,1'b0,1'b1, 8'd1, 5'd5,  6'd6,  14'd6,  8'd5},  // R5 mirror
      '{16'h4000, 8'd8,   1'b0,1'b0,1'b1,1'b0, 8'd2, 5'd0,  6'd2,  14'd12, 8'd7},  // R7
      '{16'h4000, 8'd14,  1'b0,1'b0,1'b1,1'b0, 8'd1, 5'd4,  6'd6,  14'd10, 8'd7},  // R7 sram
      '{16'h0000, 8'd8,   1'b0,1'b0,1'b1,1'b0, 8'd0, 5'd4,  6'd6,  14'd0,  8'd7},  // R7 off
      '{16'h4000, 8'd2,   1'b1,1'b1,1'b1,1'b0, 8'd3, 5'd5,  6'd7,  14'd18, 8'd8},  // R8 wram
      '{16'hFFFF, 8'd5,   1'b1,1'b0,1'b0,1'b0, 8'd3, 5'd0,  6'd2,  14'd3,  8'd8},  // R8
      '{16'h4000, 8'd200, 1'b0,1'b1,1'b0,1'b1, 8'd1, 5'd0,  6'd1,  14'd1,  8'd8},  // R8 far
      '{16'h0000, 8'd1,   1'b0,1'b0,1'b0,1'b0, 8'd2, 5'd0,  6'd2,  14'd2,  8'd8}   // R8
   };

   task automatic wr_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(input logic [7:0] rg, input logic wd, input logic sq,
                        input logic ft, input logic w, input logic [7:0] bt);
      req_valid = 1'b1; req_region = rg; req_wide = wd; req_seq = sq;
      req_fetch = ft; req_write = w; req_beats = bt;
   endtask

   // counts stall cycles from the negedge after acceptance until ack
   task automatic measure(output int n, output int busy_ready);
      n = 0; busy_ready = 0;
      for (int i = 0; i < 40; i++) begin
         if (ack) break;
         if (stall) n++;
         if (req_ready) busy_ready++;
         @(negedge clk);
      end
   endtask

   task automatic access(input string tag, input logic [7:0] rg, input logic wd,
                         input logic sq, input logic ft, input logic w,
                         input logic [7:0] bt, input int ew, input int ea, input int eb);
      int n, br;
      @(negedge clk);
      drive(rg, wd, sq, ft, w, bt);
      @(negedge clk);
      req_valid = 1'b0;
      measure(n, br);
      check({tag, " wait"}, int'(wait_cycles), ew);
      check({tag, " access"}, int'(access_cycles), ea);
      check({tag, " burst"}, int'(burst_cycles), eb);
      check({tag, " stall length R11"}, n, ew);
      check({tag, " ready while busy R11"}, br, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n, br;
      repeat (3) @(negedge clk);
      // reset state
      check("R11 reset ready", int'(req_ready), 1);
      check("R11 reset stall", int'(stall), 0);
      check("R11 reset ack", int'(ack), 0);
      check("R1 reset wait", int'(wait_cycles), 0);
      rst_n = 1'b1;

      // R1: boot timing table, before any write
      access("R1 r8 n32",  8'd8,  1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 7, 9, 14);
      access("R1 r9 s16",  8'd9,  1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 2, 4, 8);
      access("R1 r11 s32", 8'd11, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 9, 11, 10);
      access("R1 r12 s16", 8'd12, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8, 10, 0);
      access("R1 r13 s32", 8'd13, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 17, 18, 14);
      access("R1 r14 n16", 8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 4, 6, 10);
      access("R1 r15",     8'd15, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 0, 2, 1);
      access("R1 r8 fetch no prefetch", 8'd8, 1'b0, 1'b0, 1'b1, 1'b0, 8'd1, 4, 6, 8);

      // table walk
      for (int k = 0; k < 17; k++) begin
         string tg;
         tg = $sformatf("R%0d vec%0d", VT[k].req, k);
         wr_cfg(VT[k].cfg);
         access(tg, VT[k].region, VT[k].wide, VT[k].seq, VT[k].fetch, VT[k].wr,
                VT[k].beats, int'(VT[k].ew), int'(VT[k].ea), int'(VT[k].eb));
      end

      // R12: a write on the same edge as a request does not apply to it
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 16'h0003;
      drive(8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      measure(n, br);
      check("R12 same-edge wait", int'(wait_cycles), 4);
      check("R12 same-edge stall", n, 4);
      access("R12 next request", 8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 8, 10, 18);

      // R11: request offered while busy is ignored
      @(negedge clk);
      drive(8'd14, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
      @(negedge clk);
      drive(8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3);
      @(negedge clk);
      req_valid = 1'b0;
      measure(n, br);
      check("R11 busy ignored wait", int'(wait_cycles), 8);
      check("R11 busy ignored access", int'(access_cycles), 10);
      check("R11 busy stall count", n, 7);
      br = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (ack) br++;
      end
      check("R11 no extra ack", br, 0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule